// File: doc/BRIEF.md
# Binary32 NaN Result Selector

This unit sits beside a two-operand single-precision datapath and supplies the result for the case where at least one operand is a NaN. It inspects both operands, sorts each into signaling NaN, quiet NaN or ordinary value, and chooses which operand becomes the result. A chosen signaling NaN is quieted before it leaves the unit. When default-NaN mode is on, a fixed canonical NaN is returned in place of the chosen operand. An invalid-operation flag goes with every result.

Four run-time inputs set the behaviour. A 2-bit policy code picks the selection rule. One bit swaps the meaning of the top fraction bit, so either value of that bit can mark a signaling NaN. One bit treats every NaN as quiet. One bit forces the canonical NaN. The datapath is combinational. A parameter places a register on the result and the flag, and by default that register is present.

Top module: `nanprop_sel`

## Requirements
- R1: An operand is a NaN when its 8 exponent bits (30:23) are all ones and its 23-bit fraction (22:0) is nonzero. With `alt_pol`=0, a NaN whose fraction bit 22 is 1 is quiet and one whose bit 22 is 0 is signaling.
- R2: With `alt_pol`=1, a NaN whose fraction bit 22 is 1 is signaling and one whose bit 22 is 0 is quiet.
- R3: With `no_snan`=1, no operand is treated as signaling. The invalid flag stays 0 and the chosen NaN is returned unchanged.
- R4: Policy code 0 (signaling first) returns A if A is signaling. Otherwise it returns B if B is signaling, then A if A is a quiet NaN, and otherwise B.
- R5: Policy code 1 (first NaN) returns A whenever A is any NaN, and otherwise returns B.
- R6: Policy code 2 (last NaN) returns B whenever B is any NaN, and otherwise returns A.
- R7: Policy code 3 (larger significand) works as follows. A signaling NaN paired with a quiet NaN yields the quiet one. A NaN paired with a non-NaN yields the NaN. Two NaNs of the same kind yield the one with the larger 23-bit fraction. If the fractions are equal, a positive A against a negative B yields A, and every other tie yields B.
- R8: With `alt_pol`=0, a chosen signaling NaN is returned with fraction bit 22 set and all other bits unchanged.
- R9: With `alt_pol`=1, a chosen signaling NaN is returned with fraction bit 22 cleared, bit 21 set, and all other bits unchanged.
- R10: With `dflt_mode`=1, the result is the canonical NaN whatever the policy: 32'h7FC00000 when `alt_pol`=0 and 32'h7FBFFFFF when `alt_pol`=1.
- R11: `invalid` is 1 exactly when at least one operand is classified as signaling. This holds for every policy, whichever operand is chosen, and in default-NaN mode.
- R12: With the output register present (default), `result` and `invalid` show the inputs that were applied before the previous rising clock edge. A synchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| policy | input | 2 | Selection rule: 0 signaling first, 1 first NaN, 2 last NaN, 3 larger significand |
| alt_pol | input | 1 | 1: fraction MSB set marks a signaling NaN |
| no_snan | input | 1 | 1: every NaN is treated as quiet |
| dflt_mode | input | 1 | 1: return the canonical NaN |
| result | output | 32 | Propagated NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Two functions can act in the same cycle. The selection rule can choose one operand while the invalid flag is raised by the other, and default-NaN mode can replace the chosen value while the flag is still computed from the inputs. The vector table sets up both collisions. In one group a quiet A is returned under the first-NaN rule while B is signaling. In another, signaling operands are given with default-NaN mode on. The result and the flag are checked separately in the same sample, so a flag that follows the chosen operand or one that is cleared by the override is caught.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  typedef enum logic [1:0] {
    POL_SIG_FIRST = 2'd0,
    POL_FIRST_NAN = 2'd1,
    POL_LAST_NAN  = 2'd2,
    POL_LARGER    = 2'd3
  } nan_policy_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
  } nan_cls_t;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  alt_pol,
  input  logic                  no_snan,
  output nan_cls_t              cls
);
  localparam int MSB = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              any_nan;
  logic              msb_sig;

  assign exp_f  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    any_nan = (&exp_f) && (|frac_f);
    // the fraction MSB means "signaling" when it matches the polarity bit
    msb_sig = (frac_f[MSB] == alt_pol);
    cls.is_nan  = any_nan;
    cls.is_snan = any_nan && !no_snan && msb_sig;
    cls.is_qnan = any_nan && (no_snan || !msb_sig);
  end

endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
  import nanprop_pkg::*;
#(
  parameter int FRAC_W = 23
) (
  input  nan_cls_t          cls_a,
  input  nan_cls_t          cls_b,
  input  logic [1:0]        policy,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  output logic              pick_b
);
  logic a_wins_size;

  // larger fraction wins; on a full fraction tie a positive A beats a negative B
  assign a_wins_size = (frac_a > frac_b) ||
                       ((frac_a == frac_b) && !sign_a && sign_b);

  always_comb begin
    pick_b = 1'b1;
    unique case (nan_policy_e'(policy))
      POL_SIG_FIRST: begin
        if (cls_a.is_snan)      pick_b = 1'b0;
        else if (cls_b.is_snan) pick_b = 1'b1;
        else if (cls_a.is_qnan) pick_b = 1'b0;
        else                    pick_b = 1'b1;
      end
      POL_FIRST_NAN: pick_b = !cls_a.is_nan;
      POL_LAST_NAN:  pick_b = cls_b.is_nan;
      POL_LARGER: begin
        if (cls_a.is_snan) begin
          if (cls_b.is_snan)      pick_b = !a_wins_size;
          else if (cls_b.is_qnan) pick_b = 1'b1;
          else                    pick_b = 1'b0;
        end else if (cls_a.is_qnan) begin
          if (cls_b.is_qnan) pick_b = !a_wins_size;
          else               pick_b = 1'b0;
        end else begin
          pick_b = 1'b1;
        end
      end
      default: pick_b = 1'b1;
    endcase
  end

endmodule

// File: rtl/nanprop_shape.sv
module nanprop_shape #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] chosen,
  input  logic                  chosen_snan,
  input  logic                  alt_pol,
  input  logic                  dflt_mode,
  output logic [EXP_W+FRAC_W:0] shaped
);
  localparam int MSB = FRAC_W - 1;

  logic [FRAC_W-1:0] quiet_frac;
  logic [FRAC_W-1:0] dflt_frac;

  always_comb begin
    quiet_frac = chosen[FRAC_W-1:0];
    if (chosen_snan) begin
      if (alt_pol) begin
        quiet_frac[MSB]   = 1'b0;
        quiet_frac[MSB-1] = 1'b1;
      end else begin
        quiet_frac[MSB]   = 1'b1;
      end
    end
    dflt_frac = alt_pol ? {1'b0, {(FRAC_W-1){1'b1}}} : {1'b1, {(FRAC_W-1){1'b0}}};
    if (dflt_mode)
      shaped = {1'b0, {EXP_W{1'b1}}, dflt_frac};
    else
      shaped = {chosen[EXP_W+FRAC_W:FRAC_W], quiet_frac};
  end

endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
  import nanprop_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  input  logic [1:0]                policy,
  input  logic                      alt_pol,
  input  logic                      no_snan,
  input  logic                      dflt_mode,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      invalid
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int N_OPS  = 2;
  localparam int MSB    = FRAC_W - 1;

  logic [W-1:0] ops [N_OPS];
  nan_cls_t     cls [N_OPS];
  logic         pick_b;
  logic [W-1:0] chosen;
  logic         chosen_snan;
  logic [W-1:0] res_c;
  logic         inv_c;
  logic         any_nan;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  generate
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
      nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .op      (ops[gi]),
        .alt_pol (alt_pol),
        .no_snan (no_snan),
        .cls     (cls[gi])
      );
    end
  endgenerate

  nanprop_pick #(.FRAC_W(FRAC_W)) u_pick (
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .policy (policy),
    .sign_a (op_a[W-1]),
    .sign_b (op_b[W-1]),
    .frac_a (op_a[FRAC_W-1:0]),
    .frac_b (op_b[FRAC_W-1:0]),
    .pick_b (pick_b)
  );

  assign chosen      = pick_b ? op_b : op_a;
  assign chosen_snan = pick_b ? cls[1].is_snan : cls[0].is_snan;
  assign inv_c       = cls[0].is_snan | cls[1].is_snan;
  assign any_nan     = cls[0].is_nan | cls[1].is_nan;

  nanprop_shape #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_shape (
    .chosen      (chosen),
    .chosen_snan (chosen_snan),
    .alt_pol     (alt_pol),
    .dflt_mode   (dflt_mode),
    .shaped      (res_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          result  <= '0;
          invalid <= 1'b0;
        end else begin
          result  <= res_c;
          invalid <= inv_c;
        end
      end

      // registered outputs follow the previous cycle's combinational answer
      assert_out_reg_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (result == $past(res_c) && invalid == $past(inv_c)));
    end else begin : g_comb
      assign result  = res_c;
      assign invalid = inv_c;
    end
  endgenerate

  // invalid can only come from a classified NaN operand
  assert_invalid_src_R11: assert property (@(posedge clk) disable iff (rst)
    inv_c |-> any_nan);

  // no-signaling mode never raises the flag
  assert_nosnan_flag_R3: assert property (@(posedge clk) disable iff (rst)
    no_snan |-> !inv_c);

  // a NaN input always yields a NaN output
  assert_result_nan_R8: assert property (@(posedge clk) disable iff (rst)
    any_nan |-> ((&res_c[W-2:FRAC_W]) && (|res_c[FRAC_W-1:0])));

  // the output is quiet under the active polarity
  assert_result_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (any_nan && !no_snan) |-> (res_c[MSB] == !alt_pol));

  // first-NaN rule keeps A when A is a NaN
  assert_first_nan_R5: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd1 && cls[0].is_nan) |-> !pick_b);

  // last-NaN rule keeps B when B is a NaN
  assert_last_nan_R6: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd2 && cls[1].is_nan) |-> pick_b);

endmodule

// File: tb/nanprop_sel_tb.sv
`timescale 1ns/1ps
module nanprop_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [1:0]  policy = '0;
  logic        alt_pol = 1'b0;
  logic        no_snan = 1'b0;
  logic        dflt_mode = 1'b0;
  logic [31:0] result;
  logic        invalid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nanprop_sel dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .policy(policy),
    .alt_pol(alt_pol), .no_snan(no_snan), .dflt_mode(dflt_mode),
    .result(result), .invalid(invalid)
  );

  // {a, b, policy, alt_pol, no_snan, dflt_mode, expected result, expected invalid}
  localparam int NV = 24;
  localparam logic [101:0] VEC [NV] = '{
    // R4 signaling first, normal polarity (R1, R8)
    {32'h7FC00001, 32'h7F800003, 2'd0, 3'b000, 32'h7FC00003, 1'b1},
    {32'h7F800005, 32'h7F800003, 2'd0, 3'b000, 32'h7FC00005, 1'b1},
    {32'h7FC00001, 32'h7FC00002, 2'd0, 3'b000, 32'h7FC00001, 1'b0},
    {32'h3F800000, 32'h7FC00002, 2'd0, 3'b000, 32'h7FC00002, 1'b0},
    // R5 first NaN; second row flags on the unchosen B (R11)
    {32'h3F800000, 32'h7F800003, 2'd1, 3'b000, 32'h7FC00003, 1'b1},
    {32'h7FC00001, 32'h7F800003, 2'd1, 3'b000, 32'h7FC00001, 1'b1},
    // R6 last NaN
    {32'h7FC00001, 32'h7F800003, 2'd2, 3'b000, 32'h7FC00003, 1'b1},
    {32'h7FC00001, 32'h3F800000, 2'd2, 3'b000, 32'h7FC00001, 1'b0},
    // R7 larger significand
    {32'h7F800005, 32'h7FC00002, 2'd3, 3'b000, 32'h7FC00002, 1'b1},
    {32'h7FC00001, 32'h7F800003, 2'd3, 3'b000, 32'h7FC00001, 1'b1},
    {32'h7FC00001, 32'h7FC00002, 2'd3, 3'b000, 32'h7FC00002, 1'b0},
    {32'h7F800005, 32'h7F800003, 2'd3, 3'b000, 32'h7FC00005, 1'b1},
    {32'hFFC00007, 32'h7FC00007, 2'd3, 3'b000, 32'h7FC00007, 1'b0},
    {32'h7FC00007, 32'hFFC00007, 2'd3, 3'b000, 32'h7FC00007, 1'b0},
    {32'h7F800005, 32'h3F800000, 2'd3, 3'b000, 32'h7FC00005, 1'b1},
    {32'h3F800000, 32'h7FC00002, 2'd3, 3'b000, 32'h7FC00002, 1'b0},
    // R2, R9 alternative polarity
    {32'h7F800009, 32'h7FC00004, 2'd0, 3'b100, 32'h7FA00004, 1'b1},
    {32'h7FC00000, 32'h7F800009, 2'd0, 3'b100, 32'h7FA00000, 1'b1},
    {32'h7F800009, 32'h3F800000, 2'd0, 3'b100, 32'h7F800009, 1'b0},
    // R3 no signaling NaNs
    {32'h7F800005, 32'h7FC00002, 2'd0, 3'b010, 32'h7F800005, 1'b0},
    {32'h3F800000, 32'h7FC00004, 2'd2, 3'b110, 32'h7FC00004, 1'b0},
    // R10 default NaN with the flag still live (R11)
    {32'h7FC00001, 32'h7F800003, 2'd0, 3'b001, 32'h7FC00000, 1'b1},
    {32'h7F800009, 32'h3F800000, 2'd1, 3'b101, 32'h7FBFFFFF, 1'b0},
    {32'h7F800005, 32'h7FC00002, 2'd3, 3'b001, 32'h7FC00000, 1'b1}
  };

  function automatic string tag_of(logic [1:0] p, logic [2:0] m);
    if (m[0])      return "R10";
    else if (m[1]) return "R3";
    else if (m[2]) return "R2/R9";
    else case (p)
      2'd0: return "R4/R1/R8";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12 reset result", result, 32'h0);
    check("R12 reset invalid", {31'b0, invalid}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      v = VEC[i];
      op_a      = v[101:70];
      op_b      = v[69:38];
      policy    = v[37:36];
      alt_pol   = v[35];
      no_snan   = v[34];
      dflt_mode = v[33];
      @(negedge clk);
      check(tag_of(v[37:36], v[35:33]), result, v[32:1]);
      check("R11 invalid", {31'b0, invalid}, {31'b0, v[0]});
    end

    // R12 latency: new inputs must not show before the next edge
    op_a = 32'h7FC00011; op_b = 32'h3F800000; policy = 2'd1;
    alt_pol = 1'b0; no_snan = 1'b0; dflt_mode = 1'b0;
    @(posedge clk);
    #1;
    check("R12 one-cycle latency", result, 32'h7FC00011);
    op_a = 32'h7FC00022;
    #5;
    check("R12 holds between edges", result, 32'h7FC00011);

    // R12 synchronous reset in mid-run clears both outputs
    @(negedge clk);
    op_a = 32'h7F800005;
    rst = 1'b1;
    @(negedge clk);
    check("R12 mid-run reset result", result, 32'h0);
    check("R12 mid-run reset invalid", {31'b0, invalid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after reset release", {31'b0, invalid}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule